// File: doc/BRIEF.md
# LCD pixel format unpacker

This block sits behind the framebuffer fetch path of a colour LCD controller. It takes one 32-bit framebuffer word at a time and breaks it into pixels. Each pixel comes out as 24-bit RGB on a valid/ready stream. The pixel depth, the red/blue exchange, the two ordering controls, the variant selector and the 2-bit board mux code are all sampled when a word is accepted. They stay attached to that word until its last pixel has left, so software may change them at any time without corrupting a word already in flight.

Depths of 8 bits or fewer are indexed. The pixel value selects one of 256 palette entries of 16 bits each. The palette is loaded through a packed write port that carries two entries per 32-bit word. Sixteen-bit depths, the 12-bit depth and the 32-bit depth are decoded directly. The basic variant has only a native 5551 16-bit mode, and the board mux code reinterprets it. The extended variant selects 5551, 565 or 444 from the depth code alone.

Top module: `lcd_pix_unpack`

## Requirements
- R1: While reset is held and just after it, pix_valid_o is 0, word_ready_o is 1 and every palette entry reads as 0.
- R2: A word is taken when word_valid_i and word_ready_o are both 1. It then yields 32/w pixels, where w is the pixel width. word_ready_o is 1 when no word is held, or in the cycle the last pixel of the held word is taken. A held pixel and its valid stay unchanged while pix_ready_i is 0 and no palette write occurs.
- R3: Depth codes are 0=1, 1=2, 2=4, 3=8, 4=16 (5551), 5=32, 6=16 (565), 7=12 (444) bits per pixel. The 16- and 12-bit codes take 2 pixels per word. With both ordering bits 0, pixel k is taken from bits [k*w +: w].
- R4: With be_pix_i=1 and be_byte_i=0, pixel k is taken from bits [32-(k+1)*w +: w], so the most significant pixel comes first.
- R5: With be_byte_i=1, the four bytes of the word are reversed first and pixels are then taken most significant first. This holds whatever be_pix_i is.
- R6: For depth codes 0 to 3, the pixel value is a palette index. Entry 2n is bits [15:0] and entry 2n+1 is bits [31:16] of packed word n, written with pal_we_i at pal_addr_i=n. In an entry, fields [4:0], [9:5] and [14:10] are each shifted left 3 to form the low, middle and high channels. Bit 15 is ignored.
- R7: A palette write is applied at the clock edge. A pixel presented in the cycle of the write still shows the old entry, and later pixels show the new one.
- R8: In the basic variant (ext_mode_i=0), depth codes 4, 6 and 7 are all read as 16-bit pixels under mux_sel_i. Code 1 gives 5551 with fields [4:0], [9:5] and [14:10]. Code 3 gives 565 with the red/blue exchange forced on. Codes 0 and 2 give 565 that obeys bgr_i. For 565 the fields are [4:0]<<3, [10:5]<<2 and [15:11]<<3.
- R9: In the extended variant (ext_mode_i=1), mux_sel_i has no effect. Code 4 is 5551, code 6 is 565, and code 7 is 444 with fields [3:0], [7:4] and [11:8], each shifted left 4.
- R10: In depth 5 one pixel is produced per word. After the R5 byte reversal when be_byte_i=1, bits [7:0], [15:8] and [23:16] are the low, middle and high channels.
- R11: pix_o is {red, green, blue} in bits [23:16], [15:8] and [7:0]. Normally red is the low channel and blue is the high channel. bgr_i=1 exchanges the two.
- R12: All configuration inputs are sampled when a word is accepted. A change while that word is still being emitted affects only later words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| depth_i | input | 3 | Pixel depth code |
| bgr_i | input | 1 | Exchange red and blue |
| be_byte_i | input | 1 | Reverse bytes, most significant pixel first |
| be_pix_i | input | 1 | Most significant pixel first, bytes as stored |
| ext_mode_i | input | 1 | 1 selects the extended variant |
| mux_sel_i | input | 2 | Board mux code for basic-variant 16-bit pixels |
| pal_we_i | input | 1 | Palette word write strobe |
| pal_addr_i | input | 7 | Packed palette word address |
| pal_wdata_i | input | 32 | Two packed palette entries |
| word_valid_i | input | 1 | Framebuffer word valid |
| word_ready_o | output | 1 | Framebuffer word can be taken |
| word_i | input | 32 | Framebuffer word |
| pix_valid_o | output | 1 | Pixel valid |
| pix_ready_i | input | 1 | Pixel taken by the sink |
| pix_o | output | 24 | RGB pixel |

## Verification
Two pairs of events can meet in one cycle. The first is a palette rewrite landing while an indexed pixel that reads the same entry is presented or stalled. The second is the last pixel of one word being taken in the same cycle as the next word is accepted, together with a configuration change. The bench provokes the first by rewriting the whole palette while 8-bit indexed words stream under random sink stalls. It provokes the second by offering words back to back and changing the depth and ordering controls right after each acceptance. A reference model updates its palette copy only after the cycle's comparison and latches its settings only on acceptance. It is compared on every cycle, so a missing bubble, an early palette update or a configuration leaking into a word in flight shows up as a miscompare.

// File: rtl/lcd_pix_pkg.sv
package lcd_pix_pkg;
  localparam int WORD_W = 32;
  localparam int CH_W   = 8;
  localparam int RGB_W  = 3 * CH_W;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    DEP_1   = 3'd0,
    DEP_2   = 3'd1,
    DEP_4   = 3'd2,
    DEP_8   = 3'd3,
    DEP_16  = 3'd4,
    DEP_32  = 3'd5,
    DEP_565 = 3'd6,
    DEP_444 = 3'd7
  } depth_e;

  typedef enum logic [1:0] {
    FMT_5551,
    FMT_565,
    FMT_444,
    FMT_888
  } fmt_e;

  typedef struct packed {
    depth_e     depth;
    logic       bgr;
    logic       be_byte;
    logic       be_pix;
    logic       ext;
    logic [1:0] mux;
  } cfg_t;

  // log2 of pixel width in bits
  function automatic logic [2:0] depth_log2(depth_e d);
    case (d)
      DEP_1:   return 3'd0;
      DEP_2:   return 3'd1;
      DEP_4:   return 3'd2;
      DEP_8:   return 3'd3;
      DEP_32:  return 3'd5;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic is_indexed(depth_e d);
    return (d == DEP_1) || (d == DEP_2) || (d == DEP_4) || (d == DEP_8);
  endfunction
endpackage

// File: rtl/lcd_pal_store.sv
module lcd_pal_store #(
  parameter int N_WORDS = 128,
  parameter int ENT_W   = 16,
  localparam int AW     = $clog2(N_WORDS),
  localparam int DW     = 2 * ENT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW:0]      ridx_i,
  output logic [ENT_W-1:0] rentry_o
);
  logic [DW-1:0] mem_q [N_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  logic [DW-1:0] rword;
  assign rword    = mem_q[ridx_i[AW:1]];
  assign rentry_o = ridx_i[0] ? rword[DW-1:ENT_W] : rword[ENT_W-1:0];

  AST_PAL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R6
endmodule

// File: rtl/lcd_pix_select.sv
module lcd_pix_select
  import lcd_pix_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  depth_e            depth_i,
  input  logic              be_byte_i,
  input  logic              be_pix_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [RGB_W-1:0]  field_o,
  output logic              last_o
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] swapped, src;
  logic [2:0]        l2;
  logic [IDX_W-1:0]  npix_m1, pos, sh;
  logic [5:0]        wbits;
  logic [RGB_W-1:0]  mask;

  for (genvar g = 0; g < NBYTES; g++) begin : g_swap
    assign swapped[8*g +: 8] = word_i[8*(NBYTES-1-g) +: 8];
  end

  assign src     = be_byte_i ? swapped : word_i;
  assign l2      = depth_log2(depth_i);
  assign npix_m1 = IDX_W'((WORD_W - 1) >> l2);
  assign pos     = (be_byte_i || be_pix_i) ? (npix_m1 - idx_i) : idx_i;
  assign sh      = IDX_W'(pos << l2);
  assign wbits   = 6'd1 << l2;
  assign mask    = RGB_W'((33'd1 << wbits) - 33'd1);
  assign field_o = RGB_W'(src >> sh) & mask;
  assign last_o  = (idx_i == npix_m1);
endmodule

// File: rtl/lcd_pix_format.sv
module lcd_pix_format
  import lcd_pix_pkg::*;
(
  input  logic [RGB_W-1:0] field_i,
  input  logic [15:0]      pal_entry_i,
  input  depth_e           depth_i,
  input  logic             bgr_i,
  input  logic             ext_i,
  input  logic [1:0]       mux_i,
  output logic [RGB_W-1:0] rgb_o
);
  fmt_e             fmt;
  logic             swap;
  logic [15:0]      s;
  logic [CH_W-1:0]  lo, mid, hi;

  always_comb begin
    swap = bgr_i;
    fmt  = FMT_5551;
    if (is_indexed(depth_i)) begin
      fmt = FMT_5551;
    end else if (depth_i == DEP_32) begin
      fmt = FMT_888;
    end else if (ext_i) begin
      case (depth_i)
        DEP_565: fmt = FMT_565;
        DEP_444: fmt = FMT_444;
        default: fmt = FMT_5551;
      endcase
    end else begin
      // basic variant: board mux reinterprets every 16-bit code
      case (mux_i)
        2'd1:    fmt = FMT_5551;
        2'd3: begin
          fmt  = FMT_565;
          swap = 1'b1;
        end
        default: fmt = FMT_565;
      endcase
    end
  end

  assign s = is_indexed(depth_i) ? pal_entry_i : field_i[15:0];

  always_comb begin
    case (fmt)
      FMT_565: begin
        lo  = {s[4:0], 3'b0};
        mid = {s[10:5], 2'b0};
        hi  = {s[15:11], 3'b0};
      end
      FMT_444: begin
        lo  = {s[3:0], 4'b0};
        mid = {s[7:4], 4'b0};
        hi  = {s[11:8], 4'b0};
      end
      FMT_888: begin
        lo  = field_i[7:0];
        mid = field_i[15:8];
        hi  = field_i[23:16];
      end
      default: begin
        lo  = {s[4:0], 3'b0};
        mid = {s[9:5], 3'b0};
        hi  = {s[14:10], 3'b0};
      end
    endcase
  end

  assign rgb_o = swap ? {hi, mid, lo} : {lo, mid, hi};
endmodule

// File: rtl/lcd_pix_unpack.sv
module lcd_pix_unpack
  import lcd_pix_pkg::*;
#(
  parameter int PAL_WORDS = 128,
  localparam int PAL_AW   = $clog2(PAL_WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          depth_i,
  input  logic                bgr_i,
  input  logic                be_byte_i,
  input  logic                be_pix_i,
  input  logic                ext_mode_i,
  input  logic [1:0]          mux_sel_i,
  input  logic                pal_we_i,
  input  logic [PAL_AW-1:0]   pal_addr_i,
  input  logic [WORD_W-1:0]   pal_wdata_i,
  input  logic                word_valid_i,
  output logic                word_ready_o,
  input  logic [WORD_W-1:0]   word_i,
  output logic                pix_valid_o,
  input  logic                pix_ready_i,
  output logic [RGB_W-1:0]    pix_o
);
  logic              busy_q;
  logic [WORD_W-1:0] word_q;
  cfg_t              cfg_q, cfg_d;
  logic [IDX_W-1:0]  idx_q;
  logic              sel_last, pix_fire, accept;
  logic [RGB_W-1:0]  field;
  logic [15:0]       pal_entry;

  assign cfg_d = '{depth: depth_e'(depth_i), bgr: bgr_i, be_byte: be_byte_i,
                   be_pix: be_pix_i, ext: ext_mode_i, mux: mux_sel_i};

  assign pix_fire     = busy_q && pix_ready_i;
  assign word_ready_o = !busy_q || (pix_fire && sel_last);
  assign accept       = word_valid_i && word_ready_o;
  assign pix_valid_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      word_q <= '0;
      cfg_q  <= '0;
      idx_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      word_q <= word_i;
      cfg_q  <= cfg_d;
      idx_q  <= '0;
    end else if (pix_fire) begin
      if (sel_last) busy_q <= 1'b0;
      else          idx_q  <= idx_q + IDX_W'(1);
    end
  end

  lcd_pix_select u_sel (
    .word_i    (word_q),
    .depth_i   (cfg_q.depth),
    .be_byte_i (cfg_q.be_byte),
    .be_pix_i  (cfg_q.be_pix),
    .idx_i     (idx_q),
    .field_o   (field),
    .last_o    (sel_last)
  );

  lcd_pal_store #(.N_WORDS(PAL_WORDS), .ENT_W(16)) u_pal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pal_we_i),
    .waddr_i  (pal_addr_i),
    .wdata_i  (pal_wdata_i),
    .ridx_i   (field[PAL_AW:0]),
    .rentry_o (pal_entry)
  );

  lcd_pix_format u_fmt (
    .field_i     (field),
    .pal_entry_i (pal_entry),
    .depth_i     (cfg_q.depth),
    .bgr_i       (cfg_q.bgr),
    .ext_i       (cfg_q.ext),
    .mux_i       (cfg_q.mux),
    .rgb_o       (pix_o)
  );

  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> word_ready_o); // R1

  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |-> !word_ready_o); // R2

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i && !pal_we_i |=> pix_valid_o && $stable(pix_o)); // R2

  AST_ONE_PIX_32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && depth_i == 3'd5 |=> sel_last); // R10
endmodule

// File: tb/lcd_pix_unpack_tb_top.sv
module lcd_pix_unpack_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  depth_i = 3'd0;
  logic        bgr_i = 1'b0, be_byte_i = 1'b0, be_pix_i = 1'b0, ext_mode_i = 1'b0;
  logic [1:0]  mux_sel_i = 2'd1;
  logic        pal_we_i = 1'b0;
  logic [6:0]  pal_addr_i = '0;
  logic [31:0] pal_wdata_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [31:0] word_i = '0;
  logic        pix_valid_o;
  logic        pix_ready_i = 1'b1;
  logic [23:0] pix_o;

  int    n_vec = 0, n_fail = 0;
  string phase = "R1";
  bit    stall_en = 1'b0;
  bit    done = 1'b0;

  always #4 clk_i = ~clk_i;

  lcd_pix_unpack dut_i (.*);

  // reference model state
  logic [31:0] pal_m [128];
  bit          m_busy = 0;
  logic [31:0] m_word;
  int          m_k, m_dep, m_mux;
  bit          m_bgr, m_bb, m_bp, m_ext;

  function automatic int width_of(int dep);
    case (dep)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      5: return 32;
      default: return 16;
    endcase
  endfunction

  function automatic logic [23:0] model_pix(logic [31:0] w, int k, int dep, bit bgr,
                                            bit bb, bit bp, bit ext, int mux);
    int bits, pos, kind;
    bit sw;
    logic [63:0] ww, f;
    logic [15:0] s;
    logic [7:0]  lo, mid, hi;
    bits = width_of(dep);
    ww   = bb ? {32'd0, w[7:0], w[15:8], w[23:16], w[31:24]} : {32'd0, w};
    pos  = (bb || bp) ? 32 - (k + 1) * bits : k * bits;
    f    = (ww >> pos) & ((64'd1 << bits) - 64'd1);
    sw   = bgr;
    s    = f[15:0];
    if (dep <= 3) begin
      kind = 0;
      s = 16'((pal_m[f[7:1]] >> (16 * int'(f[0]))) & 32'hFFFF);
    end else if (dep == 5) kind = 3;
    else if (ext) kind = (dep == 4) ? 0 : (dep == 6) ? 1 : 2;
    else if (mux == 1) kind = 0;
    else begin
      kind = 1;
      if (mux == 3) sw = 1;
    end
    case (kind)
      0: begin lo = 8'((s & 31) << 3); mid = 8'(((s >> 5) & 31) << 3); hi = 8'(((s >> 10) & 31) << 3); end
      1: begin lo = 8'((s & 31) << 3); mid = 8'(((s >> 5) & 63) << 2); hi = 8'(((s >> 11) & 31) << 3); end
      2: begin lo = 8'((s & 15) << 4); mid = 8'(((s >> 4) & 15) << 4); hi = 8'(((s >> 8) & 15) << 4); end
      default: begin lo = f[7:0]; mid = f[15:8]; hi = f[23:16]; end
    endcase
    return sw ? {hi, mid, lo} : {lo, mid, hi};
  endfunction

  // compare mid-cycle, then advance the model to the next edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      m_busy = 0;
      for (int i = 0; i < 128; i++) pal_m[i] = '0;
    end else if (!done) begin
      bit exp_rdy, last;
      logic [23:0] exp_pix;
      n_vec++;
      last    = m_busy && (m_k == 32 / width_of(m_dep) - 1);
      exp_rdy = !m_busy || (last && pix_ready_i);
      if (pix_valid_o !== m_busy) begin
        n_fail++;
        $display("FAIL %s pix_valid got %b exp %b", phase, pix_valid_o, m_busy);
      end
      if (word_ready_o !== exp_rdy) begin
        n_fail++;
        $display("FAIL %s word_ready got %b exp %b", phase, word_ready_o, exp_rdy);
      end
      if (m_busy) begin
        exp_pix = model_pix(m_word, m_k, m_dep, m_bgr, m_bb, m_bp, m_ext, m_mux);
        if (pix_o !== exp_pix) begin
          n_fail++;
          $display("FAIL %s pix got %h exp %h (dep %0d k %0d)", phase, pix_o, exp_pix, m_dep, m_k);
        end
      end
      if (m_busy && pix_ready_i) begin
        if (last) m_busy = 0;
        else m_k++;
      end
      if (word_valid_i && exp_rdy) begin
        m_busy = 1; m_k = 0; m_word = word_i; m_dep = int'(depth_i);
        m_bgr = bgr_i; m_bb = be_byte_i; m_bp = be_pix_i; m_ext = ext_mode_i;
        m_mux = int'(mux_sel_i);
      end
      if (pal_we_i) pal_m[pal_addr_i] = pal_wdata_i;
    end
  end

  always @(posedge clk_i) begin
    #1;
    pix_ready_i = stall_en ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic send_word(logic [31:0] w);
    word_valid_i = 1'b1;
    word_i = w;
    do @(negedge clk_i); while (!word_ready_o);
    @(posedge clk_i); #1;
    word_valid_i = 1'b0;
  endtask

  task automatic stream(int n);
    for (int i = 0; i < n; i++) send_word($urandom);
  endtask

  task automatic drain();
    do @(negedge clk_i); while (pix_valid_o);
    @(posedge clk_i); #1;
  endtask

  task automatic set_cfg(int dep, bit bgr, bit bb, bit bp, bit ext, int mux);
    depth_i = 3'(dep); bgr_i = bgr; be_byte_i = bb; be_pix_i = bp;
    ext_mode_i = ext; mux_sel_i = 2'(mux);
  endtask

  task automatic load_palette(int salt);
    for (int i = 0; i < 128; i++) begin
      pal_we_i = 1'b1;
      pal_addr_i = 7'(i);
      pal_wdata_i = (i * 32'h9E3779B1) ^ salt;
      @(posedge clk_i); #1;
    end
    pal_we_i = 1'b0;
  endtask

  task automatic sweep(int dep_lo, int dep_hi, bit bgr, bit bb, bit bp, bit ext, int mux);
    for (int d = dep_lo; d <= dep_hi; d++) begin
      set_cfg(d, bgr, bb, bp, ext, mux);
      stream(3);
    end
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired in %s", phase);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: idle after reset
    n_vec++;
    if (pix_valid_o !== 1'b0 || word_ready_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 valid/ready got %b%b exp 01", pix_valid_o, word_ready_o);
    end
    // R1: palette reads zero -> index 0 in 8-bit mode gives black
    set_cfg(3, 0, 0, 0, 0, 1);
    send_word(32'h0);
    drain();

    phase = "R6";
    load_palette(32'h5A5A_A5A5);
    sweep(0, 3, 0, 0, 0, 0, 1);

    phase = "R3";
    sweep(0, 5, 0, 0, 0, 1, 0);
    stall_en = 1;
    sweep(0, 5, 0, 0, 0, 0, 1);

    phase = "R4";
    sweep(0, 5, 0, 0, 1, 0, 1);
    sweep(4, 7, 0, 0, 1, 1, 2);

    phase = "R5";
    sweep(0, 5, 0, 1, 0, 0, 1);
    sweep(0, 7, 0, 1, 1, 1, 0);

    phase = "R8";
    for (int m = 0; m < 4; m++) begin
      sweep(4, 4, 0, 0, 0, 0, m);
      sweep(4, 4, 1, 0, 0, 0, m);
      sweep(6, 7, 1, 0, 0, 0, m);
    end

    phase = "R9";
    for (int m = 0; m < 4; m++) begin
      sweep(4, 7, 0, 0, 0, 1, m);
      sweep(4, 7, 1, 0, 1, 1, m);
    end

    phase = "R10";
    sweep(5, 5, 0, 0, 0, 0, 1);
    sweep(5, 5, 1, 1, 0, 1, 3);

    phase = "R11";
    sweep(0, 7, 1, 0, 0, 0, 0);
    sweep(0, 7, 1, 0, 0, 1, 1);

    phase = "R7";
    set_cfg(3, 0, 0, 0, 0, 1);
    fork
      stream(40);
      load_palette(32'h0F0F_3C3C);
    join
    drain();

    phase = "R12";
    for (int i = 0; i < 30; i++) begin
      send_word($urandom);
      set_cfg($urandom % 8, $urandom % 2, $urandom % 2, $urandom % 2,
              $urandom % 2, $urandom % 4);
    end
    drain();

    phase = "R2";
    stall_en = 0;
    set_cfg(5, 0, 0, 0, 0, 1);
    stream(10);
    stall_en = 1;
    set_cfg(4, 0, 0, 0, 1, 0);
    stream(10);
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule